// File: doc/BRIEF.md
# Multiplexed-Bus ROM and Dual Port Controller

This block is the bus-facing controller of a peripheral that holds a 2K-byte read-only memory and two 8-bit general-purpose ports behind one multiplexed address/data bus. During the address-latch strobe it captures several values from the bus side: the low address byte, three high address bits, a memory/IO select and two chip enables. The latched values then decide whether later read strobes return a ROM byte, port pin data or a direction register. They also decide whether the IO-write strobe updates a port output latch or a direction register.

Every later action is gated by the latched enables. One enable is active low and the other active high, and the block answers only when both were active at latch time. A separate IO-read strobe does the same thing as a memory read with the IO select set. A wait output pulls low while the strobe is high with both enables active, and it releases on the next rising clock edge after the strobe falls. The ROM contents come from a computed function. Three-state drivers appear as separate data and output-enable signals.

Top module: `mux_bus_rom_ports`

## Requirements
- R1: Address (bus byte plus three high bits), memory/IO select and both enables are sampled on each clock edge that sees the latch strobe high. The last such sample is held once the strobe falls, and later input changes do not alter later accesses.
- R2: The block drives neither the data bus nor the wait output, and ignores writes, unless `ce_lo_n` was 0 and `ce_hi` was 1 when latched. One active enable is not enough.
- R3: With valid enables and `rd_n` low, a latched select of 1 returns port-side data. A select of 0 returns the ROM byte at the latched 11-bit address a, which equals (a mod 256) XOR ((a div 256) * 37 mod 256).
- R4: `ior_n` low with valid enables returns the same data as a select of 1 with `rd_n` low, whatever the latched select. With `rd_n` and `ior_n` both high, `ad_oe` is 0.
- R5: `iow_n` low with valid enables writes `ad_i` on each rising edge to the target picked by the latched low address bits. The latched select has no effect on writes.
- R6: Latched address bits [1:0] decode as follows: 00 is port A, 01 is port B, 10 is the port A direction register and 11 is the port B direction register. The high address bits have no effect on port accesses.
- R7: `wait_drv` is 1 while the strobe is high and both live enables are active. It stays 1 until the first rising clock edge that sees the strobe low, and then returns to 0.
- R8: Reset (`rst` high at a rising edge) clears both direction registers, both output latches and the latched enables. After reset every port pin is an input (`pa_oe`/`pb_oe` all 0).
- R9: Each port pin's output enable equals its direction bit, where 1 means output. A port read returns the output latch bit for output pins and the pin input for input pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address-latch strobe |
| ad_i | input | 8 | Multiplexed bus, input side |
| ad_o | output | 8 | Multiplexed bus, output data |
| ad_oe | output | 1 | Bus output enable |
| a_hi | input | 3 | High ROM address bits |
| ce_lo_n | input | 1 | Chip enable, active low |
| ce_hi | input | 1 | Chip enable, active high |
| sel_io | input | 1 | Memory/IO select, 1 means IO |
| rd_n | input | 1 | Read strobe, active low |
| ior_n | input | 1 | IO-read strobe, active low |
| iow_n | input | 1 | IO-write strobe, active low |
| wait_drv | output | 1 | 1 while the wait output is driven low, 0 when high-impedance |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |

## Verification
Read data and `ad_oe` are combinational from the latched state, so they are due in the same cycle the read strobe falls. The bench pushes the expected value as it drives the strobe, and the monitor compares it at the following falling clock edge. Writes and latching take effect at the first rising edge that samples the strobe, so their expectations are queued only after that edge. `wait_drv` is checked three times: during the strobe, in the cycle after the strobe falls (still held), and after the next rising edge (released).

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  parameter int unsigned ADDR_W = 11;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned NPORTS = 2;
  localparam int unsigned HI_W  = ADDR_W - DATA_W;
  localparam int unsigned IDX_W = $clog2(NPORTS);

  // ROM image: low byte scrambled by a multiple of the page number
  function automatic logic [DATA_W-1:0] rom_byte(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] page;
    page = DATA_W'(a[ADDR_W-1:DATA_W]);
    return a[DATA_W-1:0] ^ DATA_W'(page * DATA_W'(37));
  endfunction

  // Port readback: output bits show the latch, input bits show the pins
  function automatic logic [DATA_W-1:0] pin_mix(input logic [DATA_W-1:0] pins,
                                                input logic [DATA_W-1:0] latch,
                                                input logic [DATA_W-1:0] dir);
    return (dir & latch) | (~dir & pins);
  endfunction
endpackage

// File: rtl/mbr_addr_latch.sv
module mbr_addr_latch
  import mbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [HI_W-1:0]   a_hi,
  input  logic              ce_lo_n,
  input  logic              ce_hi,
  input  logic              sel_io,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_io,
  output logic              lat_ok,
  output logic              wait_drv
);
  logic enab_live;
  logic wait_hold;

  assign enab_live = ~ce_lo_n & ce_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr  <= '0;
      lat_io    <= 1'b0;
      lat_ok    <= 1'b0;
      wait_hold <= 1'b0;
    end else begin
      wait_hold <= ale & enab_live;
      if (ale) begin
        lat_addr <= {a_hi, ad_i};
        lat_io   <= sel_io;
        lat_ok   <= enab_live;
      end
    end
  end

  assign wait_drv = (ale & enab_live) | wait_hold;

  // R1: latched state only moves while the strobe is high
  a_r1_latch_holds: assert property (@(posedge clk) disable iff (rst)
    !ale |=> ($stable(lat_addr) && $stable(lat_io) && $stable(lat_ok)));
  // R7: wait stays asserted up to the next rising edge
  a_r7_wait_held: assert property (@(posedge clk) disable iff (rst)
    (ale && enab_live) |=> wait_drv);
endmodule

// File: rtl/mbr_port_bank.sv
module mbr_port_bank
  import mbr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_dir,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [NPORTS-1:0][DATA_W-1:0] pins_i,
  output logic [NPORTS-1:0][DATA_W-1:0] out_q,
  output logic [NPORTS-1:0][DATA_W-1:0] dir_q,
  output logic [NPORTS-1:0][DATA_W-1:0] view
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[p] <= '0;
        dir_q[p] <= '0;
      end else if (hit) begin
        if (wr_dir) dir_q[p] <= wr_data;
        else        out_q[p] <= wr_data;
      end
    end

    assign view[p] = pin_mix(pins_i[p], out_q[p], dir_q[p]);

    // R8: leaving reset, the port is all inputs
    a_r8_dir_cleared: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dir_q[p] == '0 && out_q[p] == '0));
    // R5: no write strobe, no register change
    a_r5_no_stray_write: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> ($stable(dir_q[p]) && $stable(out_q[p])));
  end
endmodule

// File: rtl/mbr_read_mux.sv
module mbr_read_mux
  import mbr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          lat_ok,
  input  logic                          lat_io,
  input  logic [ADDR_W-1:0]             lat_addr,
  input  logic                          rd_n,
  input  logic                          ior_n,
  input  logic [NPORTS-1:0][DATA_W-1:0] view,
  input  logic [NPORTS-1:0][DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0]             ad_o,
  output logic                          ad_oe
);
  logic             io_path;
  logic             rd_any;
  logic [IDX_W-1:0] idx;

  assign io_path = lat_io | ~ior_n;
  assign rd_any  = ~rd_n | ~ior_n;
  assign idx     = lat_addr[IDX_W-1:0];
  assign ad_oe   = lat_ok & rd_any;

  always_comb begin
    if (!io_path)               ad_o = rom_byte(lat_addr);
    else if (lat_addr[IDX_W])   ad_o = dir_q[idx];
    else                        ad_o = view[idx];
  end

  // R4: bus released when no read strobe is low
  a_r4_idle_release: assert property (@(posedge clk) disable iff (rst)
    (rd_n && ior_n) |-> !ad_oe);
  // R2: never drive the bus for an unselected cycle
  a_r2_unselected_quiet: assert property (@(posedge clk) disable iff (rst)
    !lat_ok |-> !ad_oe);
endmodule

// File: rtl/mux_bus_rom_ports.sv
module mux_bus_rom_ports
  import mbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [HI_W-1:0]   a_hi,
  input  logic              ce_lo_n,
  input  logic              ce_hi,
  input  logic              sel_io,
  input  logic              rd_n,
  input  logic              ior_n,
  input  logic              iow_n,
  output logic              wait_drv,
  input  logic [DATA_W-1:0] pa_i,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_i,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pb_oe
);
  logic [ADDR_W-1:0]             lat_addr;
  logic                          lat_io;
  logic                          lat_ok;
  logic                          wr_en;
  logic [NPORTS-1:0][DATA_W-1:0] pins;
  logic [NPORTS-1:0][DATA_W-1:0] out_q;
  logic [NPORTS-1:0][DATA_W-1:0] dir_q;
  logic [NPORTS-1:0][DATA_W-1:0] view;

  mbr_addr_latch u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_i(ad_i), .a_hi(a_hi),
    .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .sel_io(sel_io),
    .lat_addr(lat_addr), .lat_io(lat_io), .lat_ok(lat_ok), .wait_drv(wait_drv)
  );

  assign wr_en = ~iow_n & lat_ok;
  assign pins  = {pb_i, pa_i};

  mbr_port_bank u_ports (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_idx(lat_addr[IDX_W-1:0]), .wr_dir(lat_addr[IDX_W]), .wr_data(ad_i),
    .pins_i(pins), .out_q(out_q), .dir_q(dir_q), .view(view)
  );

  mbr_read_mux u_rmux (
    .clk(clk), .rst(rst), .lat_ok(lat_ok), .lat_io(lat_io), .lat_addr(lat_addr),
    .rd_n(rd_n), .ior_n(ior_n), .view(view), .dir_q(dir_q),
    .ad_o(ad_o), .ad_oe(ad_oe)
  );

  assign pa_o  = out_q[0];
  assign pa_oe = dir_q[0];
  assign pb_o  = out_q[1];
  assign pb_oe = dir_q[1];

  // R9: pin drivers follow the direction registers, which start clear
  a_r9_oe_from_dir: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && $past(!wr_en)) |-> ($stable(pa_oe) && $stable(pb_oe)));
endmodule

// File: tb/test_mux_bus_rom_ports.sv
`timescale 1ns/1ps
module test_mux_bus_rom_ports;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0;
  logic [7:0] ad_i = '0;
  logic [7:0] ad_o;
  logic ad_oe;
  logic [2:0] a_hi = '0;
  logic ce_lo_n = 1'b1, ce_hi = 1'b0, sel_io = 1'b0;
  logic rd_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic wait_drv;
  logic [7:0] pa_i = '0, pa_o, pa_oe, pb_i = '0, pb_o, pb_oe;

  always #2.5 clk = ~clk;

  mux_bus_rom_ports i_mux_bus_rom_ports (
    .clk(clk), .rst(rst), .ale(ale), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .a_hi(a_hi), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .sel_io(sel_io),
    .rd_n(rd_n), .ior_n(ior_n), .iow_n(iow_n), .wait_drv(wait_drv),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe), .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe)
  );

  // kinds: 0 bus {oe,data}, 1 wait, 2 pa_oe, 3 pb_oe, 4 pa_o, 5 pb_o
  typedef struct { int kind; logic [8:0] exp; string req; } item_t;
  item_t sb[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_dir [2];
  logic [7:0] m_out [2];
  logic       m_ok = 0, m_io = 0;
  logic [10:0] m_addr = '0;

  function automatic logic [7:0] exp_rom(input logic [10:0] a);
    int v;
    v = ((int'(a) / 256) * 37) % 256;
    return 8'(v) ^ a[7:0];
  endfunction

  function automatic logic [7:0] exp_port(input int p);
    logic [7:0] pins, r;
    pins = (p == 0) ? pa_i : pb_i;
    for (int b = 0; b < 8; b++) r[b] = m_dir[p][b] ? m_out[p][b] : pins[b];
    return r;
  endfunction

  function automatic logic [8:0] observe(input int kind);
    case (kind)
      0: return {ad_oe, ad_o};
      1: return {8'h0, wait_drv};
      2: return {1'b0, pa_oe};
      3: return {1'b0, pb_oe};
      4: return {1'b0, pa_o};
      default: return {1'b0, pb_o};
    endcase
  endfunction

  task automatic push(input int kind, input logic [8:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compares everything due this cycle at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [8:0] act;
      bit bad;
      it  = sb.pop_front();
      act = observe(it.kind);
      if (it.kind == 0 && it.exp[8] == 1'b0) bad = (act[8] !== 1'b0);
      else bad = (act !== it.exp);
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic addr_phase(input logic lo_n, input logic hi, input logic io,
                            input logic [10:0] a);
    logic ok;
    ok = !lo_n && hi;
    tick();
    ale = 1; ad_i = a[7:0]; a_hi = a[10:8]; ce_lo_n = lo_n; ce_hi = hi; sel_io = io;
    push(1, {8'h0, ok}, "R7 wait during strobe");
    tick();
    // scramble everything after the strobe falls (R1)
    ale = 0; ad_i = ~a[7:0]; a_hi = ~a[10:8]; ce_lo_n = 1; ce_hi = 0; sel_io = ~io;
    push(1, {8'h0, ok}, "R7 wait held to edge");
    tick();
    push(1, 9'h0, "R7 wait released");
    m_ok = ok; m_io = io; m_addr = a;
  endtask

  task automatic do_read(input bit use_ior, input string req);
    logic [7:0] d;
    tick();
    if (use_ior) ior_n = 0; else rd_n = 0;
    if (!m_ok) d = 8'h0;
    else if (!(m_io || use_ior)) d = exp_rom(m_addr);
    else if (m_addr[1]) d = m_dir[m_addr[0]];
    else d = exp_port(int'(m_addr[0]));
    push(0, {m_ok, d}, req);
    tick();
    rd_n = 1; ior_n = 1;
    push(0, 9'h0, "R4 bus off when strobes high");
  endtask

  task automatic do_write(input logic [7:0] d);
    tick();
    iow_n = 0; ad_i = d;
    tick();
    iow_n = 1;
    if (m_ok) begin
      if (m_addr[1]) m_dir[m_addr[0]] = d; else m_out[m_addr[0]] = d;
    end
    push(2, {1'b0, m_dir[0]}, "R5/R9 pa_oe");
    push(3, {1'b0, m_dir[1]}, "R5/R9 pb_oe");
    push(4, {1'b0, m_out[0]}, "R5 pa_o");
    push(5, {1'b0, m_out[1]}, "R5 pb_o");
  endtask

  task automatic model_reset();
    m_dir[0] = 0; m_dir[1] = 0; m_out[0] = 0; m_out[1] = 0; m_ok = 0;
  endtask

  initial begin
    model_reset();
    repeat (3) tick();
    rst = 0;
    tick();
    push(0, 9'h0, "R8 bus off after reset");
    push(1, 9'h0, "R8 wait off after reset");
    push(2, 9'h0, "R8 port A inputs");
    push(3, 9'h0, "R8 port B inputs");

    // R3 ROM reads at several addresses
    addr_phase(0, 1, 0, 11'h000); do_read(0, "R3 rom 000");
    addr_phase(0, 1, 0, 11'h7FF); do_read(0, "R3 rom 7FF");
    addr_phase(0, 1, 0, 11'h4A3); do_read(0, "R3 rom 4A3 / R1");
    // R4 IO-read with select latched 0 still takes the IO path
    addr_phase(0, 1, 0, 11'h123); do_read(1, "R4 ior alias dir B");

    // R6 direction A, then port A with high bits set and select 0 (R5)
    addr_phase(0, 1, 1, 11'h002); do_write(8'hF0);
    addr_phase(0, 1, 0, 11'h700); do_write(8'h3C);
    pa_i = 8'hA5;
    addr_phase(0, 1, 1, 11'h000); do_read(0, "R9 port A mix via rd");
    addr_phase(0, 1, 0, 11'h000); do_read(1, "R4 port A mix via ior");

    // port B
    addr_phase(0, 1, 1, 11'h003); do_write(8'h0F);
    addr_phase(0, 1, 1, 11'h501); do_write(8'h99);
    pb_i = 8'h66;
    addr_phase(0, 1, 1, 11'h601); do_read(0, "R6 port B high bits ignored");
    addr_phase(0, 1, 1, 11'h003); do_read(0, "R6 dir B readback");
    addr_phase(0, 1, 1, 11'h002); do_read(1, "R6 dir A readback");

    // R2 gating: one enable active only
    addr_phase(0, 0, 1, 11'h000); do_read(0, "R2 ce_hi inactive read");
    do_write(8'hFF);
    addr_phase(1, 1, 1, 11'h002); do_read(1, "R2 ce_lo_n inactive read");
    do_write(8'h00);
    addr_phase(1, 0, 0, 11'h000); do_read(0, "R2 both inactive");

    // R8 reset mid-run
    tick(); rst = 1; tick(); tick(); rst = 0;
    model_reset();
    push(2, 9'h0, "R8 dir A cleared");
    push(3, 9'h0, "R8 dir B cleared");
    push(4, 9'h0, "R8 out A cleared");
    push(0, 9'h0, "R8 enables cleared");
    addr_phase(0, 1, 1, 11'h002); do_read(0, "R8 dir A reads 0");
    addr_phase(0, 1, 1, 11'h000); do_read(0, "R9 all-input port A");

    tick(); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule